// File: doc/BRIEF.md
# GPIO Edge Detect Interrupt Unit

This block watches the levels of 128 general-purpose pins, grouped in four banks of 32. The levels reach it already synchronized to the clock. On every clock it compares each pin with the level it held on the previous clock. A pin set up as an input and enabled for the matching direction then latches a sticky status bit, on a low-to-high change, a high-to-low change, or both. Software clears a status bit by writing a one to it.

The status bits drive three registered interrupt lines. Pin 0 and pin 1 each have a line of their own. The other 126 pins share one line that is the OR of their status bits. A small wake state machine watches a halted signal from the processor. While the processor is halted, any level change on a pin that is set up as an input and belongs to a fixed per-bank wake set raises a wake request. The request stays up until the halted signal drops.

The register offsets use the same layout as the neighbouring port register file. Banks 0 to 2 of each register sit at consecutive words. Bank 3 sits 0x100 above bank 0. Direction bits arrive from that register file on `pin_is_out`.

Top module: `gpio_edge_irq_unit`

## Requirements
- R1: After reset, every rise-enable, fall-enable and status word reads 0, the stored previous levels are 0, and all four outputs are low.
- R2: Rise-enable words sit at byte offsets 0x030, 0x034, 0x038 and 0x130 (banks 0 to 3). Fall-enable words sit at 0x03C, 0x040, 0x044 and 0x13C. Status words sit at 0x048, 0x04C, 0x050 and 0x148. Enable words read back what was written, and any other offset reads 0.
- R3: A pin whose level goes from 0 to 1 between two clocks sets its status bit (bit n%32 of bank n/32) on that clock, when its rise-enable bit is 1 and its direction bit is 0. The stored previous level starts at 0 after reset.
- R4: A pin whose level goes from 1 to 0 sets its status bit when its fall-enable bit is 1 and its direction bit is 0. A fall on a pin with only rise enabled, or a rise on a pin with only fall enabled, sets nothing.
- R5: A pin whose direction bit is 1 (output) never sets its status bit, whatever its enables and level changes.
- R6: Writing a status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: When an edge sets a status bit on the same clock that a write clears it, the bit ends up set.
- R8: `irq_pin0` equals status bit 0 of bank 0, and `irq_pin1` equals status bit 1 of bank 0. Both are registered and change on the same clock as the status bit.
- R9: `irq_shared` is high exactly when any status bit other than bank 0 bits 0 and 1 is set. It is registered on the same clock as the status bits.
- R10: The wake state machine has three states. RUN goes to HALTED when `cpu_halted` is 1. HALTED goes to RUN when `cpu_halted` is 0. HALTED goes to WAKE when a wake event is seen. WAKE goes to RUN when `cpu_halted` is 0. `wake_req` is 1 only in WAKE.
- R11: A wake event is a level change, in either direction, on a pin whose direction bit is 0 and whose bit is set in the wake set. The wake sets are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F for banks 0 to 3. A change on any other pin, or any change while in RUN, leaves `wake_req` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | 128 | Synchronized pin levels, pin n at bit n |
| pin_is_out | input | 128 | Direction bits from the port register file, 1 = output |
| cpu_halted | input | 1 | Processor halted indication |
| bus_addr | input | 9 | Register byte offset |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_shared | output | 1 | Interrupt shared by pins 2 to 127 |
| wake_req | output | 1 | Wake request to the processor |

## Verification
The assertions assume that `pin_is_out`, the enables and the bus inputs are stable around the clock edge. They also assume reset is held low from time zero for at least one clock, so every `$past` term reaches back only into reset cycles. The stimulus changes inputs only on falling edges, holds reset for five clocks with all pins low, and pulses `bus_wr` for exactly one clock per access. A behavioural model in the bench follows every clock, including the clock on which an edge and a clearing write meet, and the clocks on which `cpu_halted` and pin changes fall together.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int GE_BANKS  = 4;
    localparam int GE_BANK_W = 32;
    localparam int GE_ADDR_W = 9;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_RISE = 2'd1,
        REG_FALL = 2'd2,
        REG_STAT = 2'd3
    } ge_reg_kind_e;

    typedef struct packed {
        ge_reg_kind_e kind;
        logic [1:0]   bank;
    } ge_decode_t;

    typedef enum logic [1:0] {
        WK_RUN  = 2'd0,
        WK_HALT = 2'd1,
        WK_WAKE = 2'd2
    } wake_state_e;

    // Fixed per-bank set of pins allowed to wake the processor.
    function automatic logic [GE_BANK_W-1:0] ge_wake_mask(input int bank);
        logic [GE_BANK_W-1:0] m;
        case (bank)
            0:       m = 32'h8003_FE1B;
            1:       m = 32'h0020_01FC;
            2:       m = 32'hEC08_0000;
            3:       m = 32'h0012_007F;
            default: m = '0;
        endcase
        return m;
    endfunction

    // Banks 0..2 are consecutive words; bank 3 lives 0x100 above bank 0.
    function automatic ge_decode_t ge_decode(input logic [GE_ADDR_W-1:0] addr);
        ge_decode_t d;
        logic [GE_ADDR_W-1:0] shift;
        d.kind = REG_NONE;
        d.bank = 2'd0;
        for (int b = 0; b < GE_BANKS; b++) begin
            shift = (b == 3) ? GE_ADDR_W'(9'h100) : GE_ADDR_W'(4 * b);
            if (addr == GE_ADDR_W'(9'h030) + shift) begin
                d.kind = REG_RISE;
                d.bank = 2'(b);
            end
            if (addr == GE_ADDR_W'(9'h03C) + shift) begin
                d.kind = REG_FALL;
                d.bank = 2'(b);
            end
            if (addr == GE_ADDR_W'(9'h048) + shift) begin
                d.kind = REG_STAT;
                d.bank = 2'(b);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
    parameter int              W         = 32,
    parameter logic [W-1:0]    WAKE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] is_out,
    input  logic         wr_rise,
    input  logic         wr_fall,
    input  logic         wr_stat,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rise_en,
    output logic [W-1:0] fall_en,
    output logic [W-1:0] status,
    output logic [W-1:0] status_nxt,
    output logic         wake_evt
);

    logic [W-1:0] prev_lvl;
    logic [W-1:0] changed;
    logic [W-1:0] set_hits;
    logic [W-1:0] clr_bits;

    always_comb begin
        changed    = lvl ^ prev_lvl;
        set_hits   = changed & ~is_out & ((lvl & rise_en) | (~lvl & fall_en));
        clr_bits   = wr_stat ? wdata : '0;
        status_nxt = (status & ~clr_bits) | set_hits;   // set wins
        wake_evt   = |(changed & ~is_out & WAKE_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_lvl <= '0;
            rise_en  <= '0;
            fall_en  <= '0;
            status   <= '0;
        end else begin
            prev_lvl <= lvl;
            status   <= status_nxt;
            if (wr_rise) rise_en <= wdata;
            if (wr_fall) fall_en <= wdata;
        end
    end

    // R5: newly set bits were inputs on the previous clock
    assert_out_pin_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & $past(is_out)) == '0));

    // R3/R4: newly set bits had some edge enable on the previous clock
    assert_set_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & ~($past(rise_en) | $past(fall_en))) == '0));

    // R6: a bit only drops when a one was written to it
    assert_clear_by_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(status) & ~status & ~$past(clr_bits)) == '0));

endmodule

// File: rtl/gpio_edge_irq_group.sv
module gpio_edge_irq_group #(
    parameter int NPINS = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] stat_nxt,
    output logic             irq_pin0,
    output logic             irq_pin1,
    output logic             irq_shared
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pin0   <= 1'b0;
            irq_pin1   <= 1'b0;
            irq_shared <= 1'b0;
        end else begin
            irq_pin0   <= stat_nxt[0];
            irq_pin1   <= stat_nxt[1];
            irq_shared <= |stat_nxt[NPINS-1:2];
        end
    end

endmodule

// File: rtl/gpio_edge_wake_fsm.sv
module gpio_edge_wake_fsm
    import gpio_edge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halted,
    input  logic evt,
    output logic wake_req
);

    wake_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WK_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WK_RUN:  if (halted) st_d = WK_HALT;
            WK_HALT: begin
                if (!halted)  st_d = WK_RUN;
                else if (evt) st_d = WK_WAKE;
            end
            WK_WAKE: if (!halted) st_d = WK_RUN;
            default: st_d = WK_RUN;
        endcase
    end

    always_comb begin
        wake_req = (st_q == WK_WAKE);
    end

    // R10: a request is only ever seen after a halted clock
    assert_wake_after_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(halted));

    // R10: the request holds while the processor stays halted
    assert_wake_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && halted) |=> wake_req);

endmodule

// File: rtl/gpio_edge_irq_unit.sv
module gpio_edge_irq_unit
    import gpio_edge_pkg::*;
#(
    parameter int BANKS  = GE_BANKS,
    parameter int BANK_W = GE_BANK_W,
    parameter int ADDR_W = GE_ADDR_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BANKS*BANK_W-1:0]   pin_level,
    input  logic [BANKS*BANK_W-1:0]   pin_is_out,
    input  logic                      cpu_halted,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic [BANK_W-1:0]         bus_wdata,
    output logic [BANK_W-1:0]         bus_rdata,
    output logic                      irq_pin0,
    output logic                      irq_pin1,
    output logic                      irq_shared,
    output logic                      wake_req
);

    localparam int NPINS = BANKS * BANK_W;

    ge_decode_t          dec;
    logic [BANK_W-1:0]   rise_arr [BANKS];
    logic [BANK_W-1:0]   fall_arr [BANKS];
    logic [BANK_W-1:0]   stat_arr [BANKS];
    logic [NPINS-1:0]    stat_nxt_flat;
    logic [BANKS-1:0]    evt_bank;

    always_comb dec = ge_decode(bus_addr);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic sel;
        always_comb sel = bus_wr && (dec.bank == 2'(b));

        gpio_edge_bank #(
            .W         (BANK_W),
            .WAKE_MASK (ge_wake_mask(b))
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .lvl        (pin_level[b*BANK_W +: BANK_W]),
            .is_out     (pin_is_out[b*BANK_W +: BANK_W]),
            .wr_rise    (sel && dec.kind == REG_RISE),
            .wr_fall    (sel && dec.kind == REG_FALL),
            .wr_stat    (sel && dec.kind == REG_STAT),
            .wdata      (bus_wdata),
            .rise_en    (rise_arr[b]),
            .fall_en    (fall_arr[b]),
            .status     (stat_arr[b]),
            .status_nxt (stat_nxt_flat[b*BANK_W +: BANK_W]),
            .wake_evt   (evt_bank[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        unique case (dec.kind)
            REG_RISE: bus_rdata = rise_arr[dec.bank];
            REG_FALL: bus_rdata = fall_arr[dec.bank];
            REG_STAT: bus_rdata = stat_arr[dec.bank];
            default:  bus_rdata = '0;
        endcase
    end

    gpio_edge_irq_group #(.NPINS(NPINS)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_nxt   (stat_nxt_flat),
        .irq_pin0   (irq_pin0),
        .irq_pin1   (irq_pin1),
        .irq_shared (irq_shared)
    );

    gpio_edge_wake_fsm u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .halted   (cpu_halted),
        .evt      (|evt_bank),
        .wake_req (wake_req)
    );

    // R8: dedicated lines track bank 0 status bits
    assert_pin0_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pin0 == stat_arr[0][0]) && (irq_pin1 == stat_arr[0][1]));

    // R9: shared line tracks every other status bit
    assert_shared_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_shared == ((|stat_arr[0][BANK_W-1:2]) || (|stat_arr[1]) ||
                       (|stat_arr[2]) || (|stat_arr[3])));

endmodule

// File: tb/gpio_edge_irq_unit_tb.sv
module gpio_edge_irq_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] pin_level = '0;
    logic [127:0] pin_is_out = '0;
    logic         cpu_halted = 1'b0;
    logic [8:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         irq_pin0, irq_pin1, irq_shared, wake_req;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    gpio_edge_irq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .pin_is_out(pin_is_out),
        .cpu_halted(cpu_halted), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pin0(irq_pin0),
        .irq_pin1(irq_pin1), .irq_shared(irq_shared), .wake_req(wake_req)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_rise [4];
    logic [31:0] m_fall [4];
    logic [31:0] m_stat [4];
    logic [127:0] m_prev;
    int          m_wstate;   // 0 run, 1 halted, 2 wake
    logic [31:0] wmask [4] = '{32'h8003FE1B, 32'h002001FC, 32'hEC080000, 32'h0012007F};

    function automatic int bank_at(input logic [8:0] a, input int base);
        if (a == 9'(base + 'h100)) return 3;
        for (int b = 0; b < 3; b++) if (a == 9'(base + 4 * b)) return b;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 4; b++) begin
                m_rise[b] = 0; m_fall[b] = 0; m_stat[b] = 0;
            end
            m_prev = '0;
            m_wstate = 0;
        end else begin
            bit ev;
            ev = 0;
            for (int b = 0; b < 4; b++) begin
                logic [31:0] now, was, inp, setv, clrv;
                now = pin_level[b*32 +: 32];
                was = m_prev[b*32 +: 32];
                inp = ~pin_is_out[b*32 +: 32];
                setv = 0;
                for (int i = 0; i < 32; i++) begin
                    if (inp[i] && !was[i] && now[i] && m_rise[b][i]) setv[i] = 1;
                    if (inp[i] && was[i] && !now[i] && m_fall[b][i]) setv[i] = 1;
                    if (inp[i] && (was[i] != now[i]) && wmask[b][i]) ev = 1;
                end
                clrv = (bus_wr && bank_at(bus_addr, 'h48) == b) ? bus_wdata : 0;
                m_stat[b] = (m_stat[b] & ~clrv) | setv;
                if (bus_wr && bank_at(bus_addr, 'h30) == b) m_rise[b] = bus_wdata;
                if (bus_wr && bank_at(bus_addr, 'h3C) == b) m_fall[b] = bus_wdata;
            end
            m_prev = pin_level;
            case (m_wstate)
                0: if (cpu_halted) m_wstate = 1;
                1: if (!cpu_halted) m_wstate = 0; else if (ev) m_wstate = 2;
                default: if (!cpu_halted) m_wstate = 0;
            endcase
        end
    end

    // Compare outputs to the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic e0, e1, ex, ew;
            e0 = m_stat[0][0];
            e1 = m_stat[0][1];
            ex = (|m_stat[0][31:2]) | (|m_stat[1]) | (|m_stat[2]) | (|m_stat[3]);
            ew = (m_wstate == 2);
            tests++;
            if ({irq_pin0, irq_pin1, irq_shared, wake_req} != {e0, e1, ex, ew}) begin
                fails++;
                $display("FAIL R8/R9/R10 per-clock model: got %b%b%b%b expected %b%b%b%b",
                         irq_pin0, irq_pin1, irq_shared, wake_req, e0, e1, ex, ew);
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [8:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic pin(input int idx, input logic v);
        @(negedge clk);
        pin_level[idx] = v;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                tests++; fails++;
                $display("FAIL watchdog: got timeout expected completion");
                finish_run();
            end
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd("R1 rise bank0", 9'h030, 32'h0);
        rd("R1 status bank3", 9'h148, 32'h0);
        chk("R1 outputs", {28'h0, irq_pin0, irq_pin1, irq_shared, wake_req}, 32'h0);

        // R2 register map
        wr(9'h030, 32'h0000_0001);
        wr(9'h03C, 32'h0000_0002);
        wr(9'h034, 32'h0000_0100);
        wr(9'h038, 32'h0000_0040);
        wr(9'h13C, 32'h8000_0000);
        rd("R2 rise bank0", 9'h030, 32'h0000_0001);
        rd("R2 fall bank0", 9'h03C, 32'h0000_0002);
        rd("R2 rise bank1", 9'h034, 32'h0000_0100);
        rd("R2 fall bank3", 9'h13C, 32'h8000_0000);
        rd("R2 unmapped 0x000", 9'h000, 32'h0);
        rd("R2 unaligned 0x032", 9'h032, 32'h0);

        // R3 rise on pin 0, R8 dedicated line
        pin(0, 1'b1);
        rd("R3 rise pin0 status", 9'h048, 32'h1);
        chk("R8 irq_pin0", {31'h0, irq_pin0}, 32'h1);

        // R4 rise on fall-only pin sets nothing, then fall sets
        pin(1, 1'b1);
        rd("R4 rise on fall-only pin", 9'h048, 32'h1);
        pin(1, 1'b0);
        rd("R4 fall pin1 status", 9'h048, 32'h3);
        chk("R8 irq_pin1", {31'h0, irq_pin1}, 32'h1);
        chk("R9 shared low", {31'h0, irq_shared}, 32'h0);

        // R9 shared line from bank 1 pin 40
        pin(40, 1'b1);
        rd("R3 bank1 pin40", 9'h04C, 32'h0000_0100);
        chk("R9 shared high", {31'h0, irq_shared}, 32'h1);

        // R5 output pin 70 never latches
        @(negedge clk); pin_is_out[70] = 1'b1;
        pin(70, 1'b1);
        pin(70, 1'b0);
        rd("R5 output pin70", 9'h050, 32'h0);

        // R6 write-one-to-clear
        wr(9'h04C, 32'h0);
        rd("R6 zero write keeps", 9'h04C, 32'h0000_0100);
        wr(9'h04C, 32'h0000_0100);
        rd("R6 one write clears", 9'h04C, 32'h0);
        chk("R9 shared after clear", {31'h0, irq_shared}, 32'h0);

        // bank 3 via its high offsets
        pin(127, 1'b1);
        rd("R4 rise on bank3 fall-only", 9'h148, 32'h0);
        pin(127, 1'b0);
        rd("R4 fall pin127", 9'h148, 32'h8000_0000);
        wr(9'h148, 32'hFFFF_FFFF);
        rd("R6 bank3 cleared", 9'h148, 32'h0);

        // R7 set wins against a same-clock clear
        wr(9'h048, 32'h1);
        rd("R6 pin0 cleared", 9'h048, 32'h2);
        pin(0, 1'b0);
        @(negedge clk);
        pin_level[0] = 1'b1;
        bus_addr = 9'h048; bus_wdata = 32'h1; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd("R7 set wins", 9'h048, 32'h3);

        // R11 change while running does not wake
        pin(3, 1'b1);
        chk("R11 run no wake", {31'h0, wake_req}, 32'h0);

        // R10/R11 wake sequence
        @(negedge clk); cpu_halted = 1'b1;
        @(negedge clk);
        pin(2, 1'b1);
        chk("R11 pin2 not in set", {31'h0, wake_req}, 32'h0);
        @(negedge clk); pin_is_out[3] = 1'b1;
        pin(3, 1'b0);
        chk("R11 output pin3", {31'h0, wake_req}, 32'h0);
        @(negedge clk); pin_is_out[3] = 1'b0;
        pin(3, 1'b1);
        chk("R10 wake raised", {31'h0, wake_req}, 32'h1);
        repeat (3) @(negedge clk);
        chk("R10 wake held", {31'h0, wake_req}, 32'h1);
        cpu_halted = 1'b0;
        @(negedge clk);
        chk("R10 wake dropped", {31'h0, wake_req}, 32'h0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule